// File: doc/BRIEF.md
# Pad Clamp Sequencer

This block owns the isolation and power-down controls of a pad domain that several clients share. Each client asks for the domain with a one-cycle enable request and gives it back with a disable request. The block keeps a count of current users. Only the step from no users to one, and the step from one user to none, touch the pad controls. Every other request just moves the count.

Three control levels come out of the block: a core-voltage-down flag, an early clamp and a main clamp. They are also packed into a 32-bit control word. When the domain wakes, the block releases the main clamp first, then the early clamp, then the voltage-down flag. When it sleeps, it applies them in the exact reverse order. Consecutive steps are separated by a fixed number of microsecond ticks, and the tick comes from an input strobe.

While a sequence runs, `req_ready_o` is low. A client keeps its request high until the block is ready, so no request is lost. A disable with no users, or an enable when the count is already full, is refused: the block gives a one-cycle error pulse and leaves all state unchanged.

Top module: `pad_clamp_seq`

## Requirements
- R1: After reset the voltage-down flag, the early clamp and the main clamp are all asserted, the user count is 0, `req_ready_o` is 1, and `busy_o` and `err_o` are 0.
- R2: An enable accepted while the count is 0 sets the count to 1. On the accepting edge the main clamp drops to 0, the early clamp and voltage-down flag stay at 1, and `busy_o` rises.
- R3: During power-up the early clamp drops on the edge that samples the STEP_DLY-th tick after the main clamp dropped. The voltage-down flag drops on the edge that samples the next STEP_DLY-th tick, and `busy_o` falls on that same edge.
- R4: An enable accepted while the count is between 1 and its maximum minus 1 adds one to the count and changes no control output. When idle with a nonzero count, all three controls are 0.
- R5: A disable accepted while the count is above 1 subtracts one and changes no control output.
- R6: A disable accepted while the count is 1 sets the count to 0 and starts power-down. The voltage-down flag rises on the accepting edge. The early clamp rises STEP_DLY ticks later. The main clamp rises STEP_DLY ticks after that, and `busy_o` falls with it.
- R7: A disable accepted while the count is 0 raises `err_o` for exactly one cycle, and leaves the count and all controls unchanged.
- R8: An enable accepted while the count is at its maximum (2^CNT_W-1) raises `err_o` for one cycle and leaves the count and all controls unchanged.
- R9: While `busy_o` is 1, `req_ready_o` is 0 and the count does not change. A request held high through the busy period is accepted on the first edge at which the block is ready.
- R10: Enable and disable requests high in the same ready cycle cancel each other: no count change, no error, no output change.
- R11: In `ctrl_word_o`, bit 31 is the voltage-down flag, bit 30 is the early clamp and bit 29 is the main clamp, each equal to its discrete output. All other bits are 0.
- R12: A sequence step advances only on edges that sample `us_tick_i` high. Busy cycles without a tick leave the controls unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle strobe per microsecond |
| up_req_i | input | 1 | Enable request, held until accepted |
| dn_req_i | input | 1 | Disable request, held until accepted |
| req_ready_o | output | 1 | A request is accepted on this cycle's edge |
| busy_o | output | 1 | A power sequence is in progress |
| err_o | output | 1 | One-cycle pulse for a refused request |
| users_o | output | CNT_W | Current user count |
| vdown_o | output | 1 | Core voltage-down flag |
| early_clamp_o | output | 1 | Early clamp enable |
| main_clamp_o | output | 1 | Main clamp enable |
| ctrl_word_o | output | 32 | Packed control word |

## Verification
The hardest situation to reach is a request that arrives during a running sequence and has to wait out two full step delays. It is hardest of all when that request reverses the direction the domain is moving in. The stimulus holds an enable request high from the cycle right after a power-down starts. It then checks every cycle that the count stays frozen. Finally it checks that the request is taken on the first ready edge and starts power-up at once. Random tick gaps inside each sequence make the step boundaries land on irregular cycles. Tick counting in the bench then checks the exact edge of each transition.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int WORD_W    = 32;
  localparam int VDOWN_BIT = 31;
  localparam int EARLY_BIT = 30;
  localparam int MAIN_BIT  = 29;

  typedef enum logic [2:0] {
    ST_OFF = 3'd0,
    ST_UP1 = 3'd1,
    ST_UP2 = 3'd2,
    ST_ON  = 3'd3,
    ST_DN1 = 3'd4,
    ST_DN2 = 3'd5
  } pcs_state_e;

  typedef struct packed {
    logic vdown;
    logic early;
    logic main;
  } pcs_ctl_t;

  localparam pcs_ctl_t CTL_ALL_ON = '{vdown: 1'b1, early: 1'b1, main: 1'b1};
endpackage

// File: rtl/pcs_use_counter.sv
module pcs_use_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_up_i,
  input  logic             acc_dn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wake_o,
  output logic             sleep_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;

  // refused requests only raise the error; the count stays as it was
  always_comb begin
    cnt_d   = cnt_q;
    err_d   = 1'b0;
    wake_o  = 1'b0;
    sleep_o = 1'b0;
    if (acc_up_i) begin
      if (cnt_q == CNT_MAX) begin
        err_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + CNT_ONE;
        wake_o = (cnt_q == '0);
      end
    end else if (acc_dn_i) begin
      if (cnt_q == '0) begin
        err_d = 1'b1;
      end else begin
        cnt_d   = cnt_q - CNT_ONE;
        sleep_o = (cnt_q == CNT_ONE);
      end
    end
  end

  assign cnt_en = acc_up_i | acc_dn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/pcs_step_timer.sv
module pcs_step_timer #(
  parameter int STEP_DLY = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int            TW   = $clog2(STEP_DLY + 1);
  localparam logic [TW-1:0] LAST = TW'(STEP_DLY - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tcnt_en;

  assign done_o  = run_i & tick_i & (tcnt_q == LAST);
  assign tcnt_en = clr_i | (run_i & tick_i);

  always_comb begin
    if (clr_i || done_o) begin
      tcnt_d = '0;
    end else begin
      tcnt_d = tcnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (tcnt_en) begin
      tcnt_q <= tcnt_d;
    end
  end
endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
  import pcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wake_i,
  input  logic     sleep_i,
  input  logic     step_done_i,
  output pcs_ctl_t ctl_o,
  output logic     busy_o,
  output logic     step_clr_o
);
  pcs_state_e state_q, state_d;
  pcs_ctl_t   ctl_q, ctl_d;

  // power-up releases main, early, vdown; power-down applies them reversed
  always_comb begin
    state_d = state_q;
    ctl_d   = ctl_q;
    unique case (state_q)
      ST_OFF: if (wake_i) begin
        state_d    = ST_UP1;
        ctl_d.main = 1'b0;
      end
      ST_UP1: if (step_done_i) begin
        state_d     = ST_UP2;
        ctl_d.early = 1'b0;
      end
      ST_UP2: if (step_done_i) begin
        state_d     = ST_ON;
        ctl_d.vdown = 1'b0;
      end
      ST_ON: if (sleep_i) begin
        state_d     = ST_DN1;
        ctl_d.vdown = 1'b1;
      end
      ST_DN1: if (step_done_i) begin
        state_d     = ST_DN2;
        ctl_d.early = 1'b1;
      end
      ST_DN2: if (step_done_i) begin
        state_d    = ST_OFF;
        ctl_d.main = 1'b1;
      end
      default: begin
        state_d = ST_OFF;
        ctl_d   = CTL_ALL_ON;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ctl_q   <= CTL_ALL_ON;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  assign busy_o     = (state_q == ST_UP1) || (state_q == ST_UP2) ||
                      (state_q == ST_DN1) || (state_q == ST_DN2);
  assign step_clr_o = wake_i | sleep_i;
  assign ctl_o      = ctl_q;
endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq
  import pcs_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int STEP_DLY = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick_i,
  input  logic              up_req_i,
  input  logic              dn_req_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  users_o,
  output logic              vdown_o,
  output logic              early_clamp_o,
  output logic              main_clamp_o,
  output logic [WORD_W-1:0] ctrl_word_o
);
  logic     acc_up, acc_dn;
  logic     wake, sleep, step_done, step_clr, busy;
  pcs_ctl_t ctl;

  assign req_ready_o = ~busy;
  assign acc_up      = req_ready_o & up_req_i & ~dn_req_i;
  assign acc_dn      = req_ready_o & dn_req_i & ~up_req_i;

  pcs_use_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_up_i (acc_up),
    .acc_dn_i (acc_dn),
    .cnt_o    (users_o),
    .wake_o   (wake),
    .sleep_o  (sleep),
    .err_o    (err_o)
  );

  pcs_step_timer #(.STEP_DLY(STEP_DLY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (step_clr),
    .run_i  (busy),
    .tick_i (us_tick_i),
    .done_o (step_done)
  );

  pcs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_i      (wake),
    .sleep_i     (sleep),
    .step_done_i (step_done),
    .ctl_o       (ctl),
    .busy_o      (busy),
    .step_clr_o  (step_clr)
  );

  assign busy_o        = busy;
  assign vdown_o       = ctl.vdown;
  assign early_clamp_o = ctl.early;
  assign main_clamp_o  = ctl.main;

  always_comb begin
    ctrl_word_o            = '0;
    ctrl_word_o[VDOWN_BIT] = ctl.vdown;
    ctrl_word_o[EARLY_BIT] = ctl.early;
    ctrl_word_o[MAIN_BIT]  = ctl.main;
  end
endmodule

// File: rtl/pcs_clamp_checker.sv
module pcs_clamp_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             us_tick_i,
  input logic             busy_o,
  input logic             err_o,
  input logic [CNT_W-1:0] users_o,
  input logic             vdown_o,
  input logic             early_clamp_o,
  input logic             main_clamp_o,
  input logic [31:0]      ctrl_word_o
);
  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && users_o == '0) |-> (vdown_o && early_clamp_o && main_clamp_o));

  p_up_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_clamp_o) |-> (vdown_o && early_clamp_o && busy_o));

  p_up_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(early_clamp_o) |-> (vdown_o && !main_clamp_o));

  p_up_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdown_o) |-> (!early_clamp_o && !busy_o));

  p_idle_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && users_o != '0) |-> (ctrl_word_o == 32'h0));

  p_dn_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdown_o) |-> (!early_clamp_o && !main_clamp_o && busy_o));

  p_dn_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_clamp_o) |-> (vdown_o && !main_clamp_o));

  p_dn_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_clamp_o) |-> (vdown_o && early_clamp_o && !busy_o));

  // refused request (disable at zero, or enable at full count as in R8)
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(ctrl_word_o) && $stable(users_o)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(users_o));

  p_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !us_tick_i) |=> $stable(ctrl_word_o));
endmodule

bind pad_clamp_seq pcs_clamp_checker #(.CNT_W(CNT_W)) u_pcs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .us_tick_i     (us_tick_i),
  .busy_o        (busy_o),
  .err_o         (err_o),
  .users_o       (users_o),
  .vdown_o       (vdown_o),
  .early_clamp_o (early_clamp_o),
  .main_clamp_o  (main_clamp_o),
  .ctrl_word_o   (ctrl_word_o)
);

// File: tb/tb_pad_clamp_seq.sv
module tb_pad_clamp_seq;
  localparam int CW   = 4;
  localparam int D    = 100;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          us_tick, up_req, dn_req;
  logic          req_ready, busy, err;
  logic [CW-1:0] users;
  logic          vdown, early, mainc;
  logic [31:0]   word;

  int n_chk;
  int n_err;
  int m_cnt;
  bit reported;

  pad_clamp_seq #(.CNT_W(CW), .STEP_DLY(D)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .us_tick_i     (us_tick),
    .up_req_i      (up_req),
    .dn_req_i      (dn_req),
    .req_ready_o   (req_ready),
    .busy_o        (busy),
    .err_o         (err),
    .users_o       (users),
    .vdown_o       (vdown),
    .early_clamp_o (early),
    .main_clamp_o  (mainc),
    .ctrl_word_o   (word)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] w3(input bit v, input bit e, input bit m);
    return {v, e, m, 29'b0};
  endfunction

  // expected word after t ticks of a sequence in the given direction
  function automatic logic [31:0] seq_word(input bit up, input int t);
    if (up) return (t < D) ? w3(1, 1, 0) : (t < 2 * D) ? w3(1, 0, 0) : w3(0, 0, 0);
    return (t < D) ? w3(1, 0, 0) : (t < 2 * D) ? w3(1, 1, 0) : w3(1, 1, 1);
  endfunction

  function automatic logic [31:0] steady_word(input int cnt);
    return (cnt == 0) ? w3(1, 1, 1) : 32'h0;
  endfunction

  // called at the negedge after the accepting edge; steps with random tick gaps
  task automatic track_seq(input bit up, input string tag);
    int t = 0;
    int g = 0;
    while (busy && g < 5000) begin
      check({tag, " R3/R6/R12 step word"}, word, seq_word(up, t));
      check("R11 discrete vs word", {vdown, early, mainc, 29'b0}, word);
      check("R9 not ready while busy", {31'b0, req_ready}, 32'd0);
      check("R9 count frozen while busy", {28'b0, users}, m_cnt);
      us_tick = (($urandom % 3) != 0);
      step();
      if (us_tick) t++;
      us_tick = 1'b0;
      g++;
    end
    check({tag, " R3/R6 ticks per sequence"}, t, 2 * D);
    check({tag, " R3/R6 final word"}, word, seq_word(up, 2 * D));
  endtask

  // kind: 0 enable, 1 disable, 2 both together
  task automatic do_op(input int kind, input string tag);
    bit e_err = 1'b0;
    bit start = 1'b0;
    bit dir   = 1'b0;
    int g = 0;
    case (kind)
      0: if (m_cnt == MAXC) e_err = 1'b1;
         else begin start = (m_cnt == 0); dir = 1'b1; m_cnt++; end
      1: if (m_cnt == 0) e_err = 1'b1;
         else begin m_cnt--; start = (m_cnt == 0); dir = 1'b0; end
      default: ;
    endcase
    up_req = (kind != 1);
    dn_req = (kind != 0);
    while (!req_ready && g < 5000) begin step(); g++; end
    step();
    up_req = 1'b0;
    dn_req = 1'b0;
    check({tag, " R7/R8/R10 err"}, {31'b0, err}, {31'b0, e_err});
    check({tag, " R4/R5 count"}, {28'b0, users}, m_cnt);
    check({tag, " R2/R6 busy start"}, {31'b0, busy}, {31'b0, start});
    if (start) begin
      track_seq(dir, tag);
    end else begin
      check({tag, " R4/R5/R10 word unchanged"}, word, steady_word(m_cnt));
    end
    if (e_err) begin
      step();
      check({tag, " R7 one-cycle err pulse"}, {31'b0, err}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C3E1));
    n_chk = 0; n_err = 0; m_cnt = 0; reported = 1'b0;
    rst_n = 1'b0; us_tick = 1'b0; up_req = 1'b0; dn_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 reset word", word, w3(1, 1, 1));
    check("R1 reset count", {28'b0, users}, 32'd0);
    check("R1 reset ready", {31'b0, req_ready}, 32'd1);
    check("R1 reset busy/err", {30'b0, busy, err}, 32'd0);

    do_op(1, "R7 disable at zero");
    do_op(0, "R2 first enable");
    do_op(0, "R4 second enable");
    do_op(1, "R5 non-last disable");
    do_op(2, "R10 both at once");

    // R9: enable held from the start of a power-down
    dn_req = 1'b1;
    step();
    dn_req = 1'b0;
    m_cnt = 0;
    check("R6 power-down started", {31'b0, busy}, 32'd1);
    up_req = 1'b1;
    track_seq(1'b0, "R9 held enable");
    check("R9 ready after sequence", {31'b0, req_ready}, 32'd1);
    step();
    up_req = 1'b0;
    m_cnt = 1;
    check("R9 held request accepted", {28'b0, users}, 32'd1);
    check("R9 power-up started", {31'b0, busy}, 32'd1);
    track_seq(1'b1, "R9 power-up");

    while (m_cnt < MAXC) do_op(0, "R4 fill");
    do_op(0, "R8 enable at max");
    while (m_cnt > 0) do_op(1, "R6 drain");

    for (int i = 0; i < 200; i++) begin
      int r = $urandom % 20;
      do_op((r < 9) ? 0 : (r < 18) ? 1 : 2, "random");
    end

    summary();
    $finish;
  end
endmodule